// File: doc/BRIEF.md
# Frame Error Status Flags

This block gathers the frame-level fault events of a CAN controller into one status byte and raises a single interrupt request for them. Two inputs are single-cycle event pulses (receive pre-buffer overflow and arbitration lost). Three are level signals (error-warning, error-passive and bus-off), and for these a flag is set whenever the level changes in either direction. Software clears most flags by writing 1 to their bit. The arbitration-lost flag instead clears when the CPU reads the arbitration capture register, which reaches this block as a one-cycle strobe.

A pre-buffer overflow is detected before acceptance filtering, so its flag carries no message-object number. The block also outputs a summary bit that a top-level interrupt flag register shows as read-only. That summary bit can only be cleared by clearing the flags beneath it. The bit-timing engine, the error counters and the acceptance filters are outside this block.

Top module: `fes_flag_bank`

## Requirements
- R1: A pulse on `ovf_evt` sets status bit 5. A write with `wr_data[5]`=1 clears it.
- R2: A pulse on `arb_evt` sets status bit 4. Writes leave bit 4 unchanged in both directions. A pulse on `cap_rd` clears it.
- R3: Status bit 1 is set on every change of `warn_lvl`, rising or falling. A write with `wr_data[1]`=1 clears it.
- R4: Status bit 0 is set on every change of `pass_lvl`, rising or falling. A write with `wr_data[0]`=1 clears it.
- R5: Status bit 2 is set on every change of `boff_lvl`, both entry into and exit from bus-off. A write with `wr_data[2]`=1 clears it.
- R6: If a set event and a clear (write-1 or `cap_rd`) reach the same flag in the same cycle, the flag ends up set.
- R7: Reset clears every flag and sets every tracked level to 0. Status bits 3, 6 and 7 always read 0, and writes do not change them. A level that is already 1 in the first cycle after reset counts as a change.
- R8: `fe_irq` is 1 exactly when some status bit i is 1 and `irq_en[i]` was 1 at the same clock edge. It stays 1 for as long as such a flag remains set.
- R9: `fe_sum` is 1 exactly when any status bit is 1, whatever the enables are. It drops only when the flags are cleared.
- R10: `status`, `fe_irq` and `fe_sum` are registered. They take their new value at the rising edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 1 | Receive pre-buffer overflow pulse |
| arb_evt | input | 1 | Arbitration lost pulse |
| warn_lvl | input | 1 | Error-warning level |
| pass_lvl | input | 1 | Error-passive level |
| boff_lvl | input | 1 | Bus-off level |
| wr_en | input | 1 | CPU write strobe for the status byte |
| wr_data | input | 8 | Write data; a 1 clears the flag in that position |
| cap_rd | input | 1 | Strobe for a read of the arbitration capture register |
| irq_en | input | 8 | Per-flag interrupt enables, same bit positions as status |
| status | output | 8 | Status byte |
| fe_sum | output | 1 | Read-only summary bit for the top-level flag register |
| fe_irq | output | 1 | Frame-error interrupt request |

## Verification
Every result is due one rising edge after its stimulus: flags, the summary bit and the interrupt all update at the edge that samples the pulse, level change, write or enable. The bench drives each input on a falling edge and reads the outputs on the next falling edge, so every check sits exactly one edge after its stimulus. Directed tests use the same spacing to cover the first cycle after reset, and a flag that must survive many idle and write cycles is re-read after each one.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int STAT_W = 8;
  localparam int LVL_N  = 3;
  // bit positions of the flags
  localparam int PASS_B = 0;
  localparam int WARN_B = 1;
  localparam int BOFF_B = 2;
  localparam int ARB_B  = 4;
  localparam int OVF_B  = 5;
  // flags cleared by a write of 1
  localparam logic [STAT_W-1:0] W1C_MASK =
    STAT_W'((1 << OVF_B) | (1 << BOFF_B) | (1 << WARN_B) | (1 << PASS_B));
  // all implemented flags
  localparam logic [STAT_W-1:0] USED_MASK = W1C_MASK | STAT_W'(1 << ARB_B);
endpackage

// File: rtl/fes_edge_det.sv
module fes_edge_det #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign chg = lvl ^ prev_q;
endmodule

// File: rtl/fes_flag_cell.sv
module fes_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  // a set takes priority over a clear in the same cycle
  assign nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/fes_flag_bank.sv
module fes_flag_bank
  import fes_pkg::*;
#(
  parameter int W    = STAT_W,
  parameter int NLVL = LVL_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ovf_evt,
  input  logic         arb_evt,
  input  logic         warn_lvl,
  input  logic         pass_lvl,
  input  logic         boff_lvl,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cap_rd,
  input  logic [W-1:0] irq_en,
  output logic [W-1:0] status,
  output logic         fe_sum,
  output logic         fe_irq
);
  localparam logic [W-1:0] CLR_M  = W'(W1C_MASK);
  localparam logic [W-1:0] USED_M = W'(USED_MASK);

  logic [NLVL-1:0] lvl_vec;
  logic [NLVL-1:0] lvl_chg;
  logic [W-1:0]    set_vec;
  logic [W-1:0]    clr_vec;
  logic [W-1:0]    flag_d;
  logic [W-1:0]    flag_q;
  logic            sum_q;
  logic            irq_q;

  assign lvl_vec = {boff_lvl, warn_lvl, pass_lvl};

  fes_edge_det #(.W(NLVL)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (lvl_vec),
    .chg (lvl_chg)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[OVF_B]  = ovf_evt;
    set_vec[ARB_B]  = arb_evt;
    set_vec[PASS_B] = lvl_chg[0];
    set_vec[WARN_B] = lvl_chg[1];
    set_vec[BOFF_B] = lvl_chg[2];
  end

  always_comb begin
    clr_vec        = wr_en ? (wr_data & CLR_M) : '0;
    clr_vec[ARB_B] = cap_rd;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (USED_M[i]) begin : g_flag
      fes_flag_cell u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .nxt_o (flag_d[i]),
        .q_o   (flag_q[i])
      );
    end else begin : g_zero
      assign flag_d[i] = 1'b0;
      assign flag_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= |flag_d;
      irq_q <= |(flag_d & irq_en);
    end
  end

  assign status = flag_q;
  assign fe_sum = sum_q;
  assign fe_irq = irq_q;
endmodule

// File: rtl/fes_flag_bank_chk.sv
module fes_flag_bank_chk (
  input logic       clk,
  input logic       rst,
  input logic       ovf_evt,
  input logic       arb_evt,
  input logic       warn_lvl,
  input logic       pass_lvl,
  input logic       boff_lvl,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       cap_rd,
  input logic [7:0] irq_en,
  input logic [7:0] status,
  input logic       fe_sum,
  input logic       fe_irq
);
  logic [2:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= {boff_lvl, warn_lvl, pass_lvl};
  end

  p_ovf_set_r1: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> status[5]);
  p_ovf_clr_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[5] && !ovf_evt) |=> !status[5]);
  p_arb_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!arb_evt && !cap_rd) |=> $stable(status[4]));
  p_arb_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (cap_rd && !arb_evt) |=> !status[4]);
  p_warn_chg_r3: assert property (@(posedge clk) disable iff (rst)
    (warn_lvl != seen_q[1]) |=> status[1]);
  p_pass_chg_r4: assert property (@(posedge clk) disable iff (rst)
    (pass_lvl != seen_q[0]) |=> status[0]);
  p_boff_chg_r5: assert property (@(posedge clk) disable iff (rst)
    (boff_lvl != seen_q[2]) |=> status[2]);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && wr_en && wr_data[5]) |=> status[5]);
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (status == 8'h00 && !fe_irq && !fe_sum));
  p_unused_r7: assert property (@(posedge clk) disable iff (rst)
    (status[7:6] == 2'b00) && !status[3]);
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fe_irq == |(status & $past(irq_en))));
  p_sum_r9: assert property (@(posedge clk) disable iff (rst)
    fe_sum == (|status));
endmodule

bind fes_flag_bank fes_flag_bank_chk u_chk (
  .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .arb_evt(arb_evt),
  .warn_lvl(warn_lvl), .pass_lvl(pass_lvl), .boff_lvl(boff_lvl),
  .wr_en(wr_en), .wr_data(wr_data), .cap_rd(cap_rd), .irq_en(irq_en),
  .status(status), .fe_sum(fe_sum), .fe_irq(fe_irq)
);

// File: tb/fes_flag_bank_test.sv
`timescale 1ns/1ps
module fes_flag_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ovf_evt = 1'b0, arb_evt = 1'b0;
  logic       warn_lvl = 1'b0, pass_lvl = 1'b0, boff_lvl = 1'b0;
  logic       wr_en = 1'b0, cap_rd = 1'b0;
  logic [7:0] wr_data = 8'h00, irq_en = 8'h00;
  logic [7:0] status;
  logic       fe_sum, fe_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fes_flag_bank uut (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .arb_evt(arb_evt),
    .warn_lvl(warn_lvl), .pass_lvl(pass_lvl), .boff_lvl(boff_lvl),
    .wr_en(wr_en), .wr_data(wr_data), .cap_rd(cap_rd), .irq_en(irq_en),
    .status(status), .fe_sum(fe_sum), .fe_irq(fe_irq)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       ovf, arb, warn, pass, boff, wr;
    logic [7:0] wd;
    logic       cap;
    logic [7:0] en;
    logic [7:0] est;
    logic       eirq, esum;
  } vec_t;

  localparam int NV = 26;
  // req, ovf, arb, warn, pass, boff, wr, wd, cap, en, est, eirq, esum
  localparam vec_t TBL [NV] = '{
    '{4'd7, 0,0,0,0,0, 0,8'h00, 0,8'h00, 8'h00, 0,0}, // R7 idle after reset
    '{4'd1, 1,0,0,0,0, 0,8'h00, 0,8'h20, 8'h20, 1,1}, // R1 overflow set, R8
    '{4'd1, 0,0,0,0,0, 1,8'h20, 0,8'h20, 8'h00, 0,0}, // R1 write-1 clear
    '{4'd2, 0,1,0,0,0, 0,8'h00, 0,8'h10, 8'h10, 1,1}, // R2 arb set
    '{4'd2, 0,0,0,0,0, 1,8'hFF, 0,8'h10, 8'h10, 1,1}, // R2 write ignored
    '{4'd2, 0,0,0,0,0, 0,8'h00, 1,8'h10, 8'h00, 0,0}, // R2 capture read clears
    '{4'd3, 0,0,1,0,0, 0,8'h00, 0,8'h00, 8'h02, 0,1}, // R3 rise, R9 masked sum
    '{4'd3, 0,0,1,0,0, 1,8'h02, 0,8'h00, 8'h00, 0,0}, // R3 clear
    '{4'd3, 0,0,0,0,0, 0,8'h00, 0,8'h02, 8'h02, 1,1}, // R3 fall sets
    '{4'd3, 0,0,0,0,0, 1,8'h02, 0,8'h02, 8'h00, 0,0}, // R3 clear
    '{4'd4, 0,0,0,1,0, 0,8'h00, 0,8'h01, 8'h01, 1,1}, // R4 rise
    '{4'd4, 0,0,0,0,0, 0,8'h00, 0,8'h01, 8'h01, 1,1}, // R4 fall keeps set
    '{4'd4, 0,0,0,0,0, 1,8'h01, 0,8'h01, 8'h00, 0,0}, // R4 clear
    '{4'd5, 0,0,0,0,1, 0,8'h00, 0,8'h04, 8'h04, 1,1}, // R5 bus-off entry
    '{4'd5, 0,0,0,0,1, 1,8'h04, 0,8'h04, 8'h00, 0,0}, // R5 clear
    '{4'd5, 0,0,0,0,0, 0,8'h00, 0,8'h04, 8'h04, 1,1}, // R5 bus-off exit
    '{4'd5, 0,0,0,0,0, 1,8'h04, 0,8'h04, 8'h00, 0,0}, // R5 clear
    '{4'd6, 1,0,0,0,0, 1,8'h20, 0,8'h00, 8'h20, 0,1}, // R6 set beats write
    '{4'd6, 0,0,0,0,0, 1,8'h20, 0,8'h00, 8'h00, 0,0}, // R6 then clears
    '{4'd6, 0,1,0,0,0, 0,8'h00, 1,8'h00, 8'h10, 0,1}, // R6 set beats read
    '{4'd6, 0,0,0,0,0, 0,8'h00, 1,8'h00, 8'h00, 0,0}, // R6 then clears
    '{4'd6, 0,0,1,0,0, 1,8'h02, 0,8'h00, 8'h02, 0,1}, // R6 level edge vs write
    '{4'd7, 0,0,1,0,0, 1,8'hFF, 0,8'hFF, 8'h00, 0,0}, // R7 bits 3,6,7 stay 0
    '{4'd8, 1,1,0,1,1, 0,8'h00, 0,8'h00, 8'h37, 0,1}, // R8 all masked
    '{4'd8, 0,0,0,1,1, 0,8'h00, 0,8'hFF, 8'h37, 1,1}, // R8 enable opens
    '{4'd9, 0,0,0,1,1, 1,8'hFF, 1,8'hFF, 8'h00, 0,0}  // R9 all cleared
  };

  task automatic check(input string tag, input logic [7:0] st_a, input logic [7:0] st_e,
                       input logic irq_a, input logic irq_e, input logic sum_a, input logic sum_e);
    checks++;
    if (st_a !== st_e || irq_a !== irq_e || sum_a !== sum_e) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b sum=%b expected status=%h irq=%b sum=%b",
               tag, st_a, irq_a, sum_a, st_e, irq_e, sum_e);
    end
  endtask

  task automatic idle();
    ovf_evt = 0; arb_evt = 0; wr_en = 0; wr_data = 8'h00; cap_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset", status, 8'h00, fe_irq, 1'b0, fe_sum, 1'b0);
    rst = 0;
    // R10: each row is applied on one falling edge and read on the next
    for (int i = 0; i < NV; i++) begin
      ovf_evt = TBL[i].ovf; arb_evt = TBL[i].arb; warn_lvl = TBL[i].warn;
      pass_lvl = TBL[i].pass; boff_lvl = TBL[i].boff; wr_en = TBL[i].wr;
      wr_data = TBL[i].wd; cap_rd = TBL[i].cap; irq_en = TBL[i].en;
      @(negedge clk);
      check($sformatf("R%0d row %0d", TBL[i].req, i), status, TBL[i].est,
            fe_irq, TBL[i].eirq, fe_sum, TBL[i].esum);
    end
    // R2: arb flag survives idle cycles and writes until the capture read
    idle(); irq_en = 8'h10; arb_evt = 1;
    @(negedge clk); arb_evt = 0;
    for (int k = 0; k < 5; k++) begin
      wr_en = k[0]; wr_data = 8'hFF;
      @(negedge clk);
      check("R2 hold", status, 8'h10, fe_irq, 1'b1, fe_sum, 1'b1);
    end
    idle();
    // R7: reset mid-operation clears flags; a high level at release counts as a change
    warn_lvl = 0; pass_lvl = 1; boff_lvl = 0; rst = 1;
    @(negedge clk);
    check("R7 reset clears", status, 8'h00, fe_irq, 1'b0, fe_sum, 1'b0);
    rst = 0; irq_en = 8'h01;
    @(negedge clk);
    check("R7 level high at release", status, 8'h01, fe_irq, 1'b1, fe_sum, 1'b1);
    // R10 and R8: removing the enable drops the interrupt one edge later
    irq_en = 8'h00;
    @(negedge clk);
    check("R10 enable removal", status, 8'h01, fe_irq, 1'b0, fe_sum, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule